// File: doc/BRIEF.md
# Pipelined Four-Beat Burst Synchronous SRAM

This block is a single-clock synchronous static memory. Every input except the output enable is captured on the rising clock edge. Read data comes out through one pipeline register. An internal two-bit counter turns one presented address into a burst of four words that stay inside the same aligned four-word block. The array depth is a parameter, so the memory fits in ordinary registers. The block can stand in for an external burst SRAM in a larger design or serve as an on-chip scratch memory with burst access.

An access starts in a selected cycle that has the address strobe low. In later selected cycles the burst either steps to its next word or repeats the current word, as the advance input decides. A burst-order input, sampled when the access starts, picks linear or interleaved sequencing. The write controls are layered: a global write enable, a byte-write enable and one select per byte lane. Write data is taken one cycle after its address beat. Deselecting ends the burst, and the output stops driving one cycle later. A sleep input freezes all burst state and ignores every access.

Top module: `psram_burst`

## Requirements
- R1: While reset is asserted and right after it, `dout_drive` is 0 and `dout` is all zeros.
- R2: A read beat registered at edge k is presented on `dout` with `dout_drive` high after edge k+1, provided `oe_n` is low.
- R3: A burst keeps address bits above bit 1 equal to the loaded address. Only the low two bits follow the burst sequence, and the first beat uses the loaded address itself.
- R4: In a selected cycle with `ads_n`=1 inside a burst, `adv_n`=0 steps the two-bit counter by one. After the fourth beat it wraps, so the fifth beat reads the start address again.
- R5: In such a cycle, `adv_n`=1 holds the counter, and the beat repeats the previous address.
- R6: `lbo_n`=1 at load selects interleaved order, where the low bits are the start bits XOR the counter. `lbo_n`=0 selects linear order, where the low bits are the start bits plus the counter, modulo 4.
- R7: With `gw_n`=0 all lanes are written. Otherwise, with `bwe_n`=0, lane i (bits 9i+8..9i) is written when `bw_n[i]`=0. A beat that writes no lane is a read. A write beat takes its data from `din` in the following cycle, and during a write beat the output is not driven.
- R8: A read beat issued in the cycle right after a write beat to the same address returns the newly written data.
- R9: A cycle with `ce_n`=1, `cs0`=0 or `cs1_n`=1 issues no beat and ends the burst. The output stops driving after the next edge. Later cycles with `ads_n`=1 issue no beat until a new load.
- R10: `oe_n`=1 forces `dout_drive` low and `dout` to zero at once, without a clock edge, and does not disturb the pipeline.
- R11: While `zz`=1, no beat is issued, no write takes place, and the burst counter and the burst state hold, so the burst goes on from where it stopped once `zz` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | ADDR_W | Word address, loaded when `ads_n` is low |
| din | input | LANES*LANE_W | Write data, taken one cycle after its write beat |
| ads_n | input | 1 | Active-low address load; starts a burst |
| adv_n | input | 1 | Active-low burst advance |
| lbo_n | input | 1 | Burst order: 1 interleaved, 0 linear |
| ce_n | input | 1 | Active-low chip enable |
| cs0 | input | 1 | Active-high chip select |
| cs1_n | input | 1 | Active-low chip select |
| gw_n | input | 1 | Active-low global write, all lanes |
| bwe_n | input | 1 | Active-low byte-write enable |
| bw_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| zz | input | 1 | Sleep: ignore accesses, hold state |
| dout | output | LANES*LANE_W | Read data; zero when not driven |
| dout_drive | output | 1 | High when `dout` carries valid read data (low stands for high impedance) |

## Verification
Each cycle's stimulus has a fixed result two edges later. The beat is registered at the first edge, and its word, or an undriven output for writes, deselects, sleep and idle cycles, appears after the second. The driver stamps each expected item with that edge number, and the monitor compares it 2 ns after the edge. Write data follows its beat by one cycle, so the driver holds it back one cycle and updates its own reference array at the beat. Output-enable effects are combinational and are checked 1 ns after `oe_n` is toggled in the middle of a cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int BURST_LEN = 4;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ step;
    else            r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ads_n,
  input  logic              adv_n,
  input  logic              lbo_n,
  input  logic              ce_n,
  input  logic              cs0,
  input  logic              cs1_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              zz,
  output logic              beat_v,
  output logic              beat_wr,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANES-1:0]  beat_mask
);

  logic              selected;
  logic              load_fire;
  logic              cont_fire;
  logic              cnt_step;
  logic [1:0]        cnt;
  logic [1:0]        cnt_nxt;
  logic              active;
  logic              ilv;
  logic [ADDR_W-1:0] base;
  logic [LANES-1:0]  mask_now;

  always_comb begin
    selected  = !ce_n && cs0 && !cs1_n;
    load_fire = !zz && selected && !ads_n;
    cont_fire = !zz && selected && ads_n && active;
    cnt_step  = cont_fire && !adv_n;
    cnt_nxt   = cnt_step ? cnt + 2'd1 : cnt;
    if (!gw_n)       mask_now = '1;
    else if (!bwe_n) mask_now = ~bw_n;
    else             mask_now = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= 2'd0;
      ilv       <= 1'b0;
      base      <= '0;
      beat_v    <= 1'b0;
      beat_wr   <= 1'b0;
      beat_addr <= '0;
      beat_mask <= '0;
    end else begin
      if (load_fire) begin
        base   <= addr;
        ilv    <= lbo_n;
        cnt    <= 2'd0;
        active <= 1'b1;
      end else if (cont_fire) begin
        cnt <= cnt_nxt;
      end else if (!zz && !selected) begin
        active <= 1'b0;
      end
      beat_v    <= load_fire || cont_fire;
      beat_wr   <= (load_fire || cont_fire) && (|mask_now);
      beat_mask <= mask_now;
      if (load_fire)
        beat_addr <= addr;
      else if (cont_fire)
        beat_addr <= {base[ADDR_W-1:2], burst_low(base[1:0], cnt_nxt, ilv)};
    end
  end

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |=> (cnt == $past(cnt) + 2'd1));

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_fire && adv_n) |=> (beat_v && $stable(beat_addr)));

  p_gw_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && !gw_n) |=> (beat_wr && (&beat_mask)));

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> (!beat_v && $stable(cnt) && $stable(active)));

endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g])
        mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/psram_out.sv
module psram_out #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [DW-1:0] rd_data,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_drive
);

  logic [DW-1:0] q;
  logic          q_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= rd_fire;
      if (rd_fire) q <= rd_data;
    end
  end

  assign dout_drive = q_valid && !oe_n;
  assign dout       = dout_drive ? q : '0;

  p_desel_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !dout_drive);

endmodule

// File: rtl/psram_burst.sv
module psram_burst #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    ads_n,
  input  logic                    adv_n,
  input  logic                    lbo_n,
  input  logic                    ce_n,
  input  logic                    cs0,
  input  logic                    cs1_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    zz,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drive
);

  localparam int DW = LANES * LANE_W;

  logic              beat_v;
  logic              beat_wr;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  beat_mask;
  logic [DW-1:0]     rd_data;
  logic              wr_fire;
  logic              rd_fire;

  assign wr_fire = beat_v && beat_wr;
  assign rd_fire = beat_v && !beat_wr;

  psram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_n(ads_n), .adv_n(adv_n),
    .lbo_n(lbo_n), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .zz(zz), .beat_v(beat_v), .beat_wr(beat_wr),
    .beat_addr(beat_addr), .beat_mask(beat_mask)
  );

  psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(wr_fire), .wr_addr(beat_addr), .wr_mask(beat_mask),
    .wr_data(din), .rd_addr(beat_addr), .rd_data(rd_data)
  );

  psram_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_data(rd_data),
    .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive)
  );

endmodule

// File: tb/psram_burst_tb.sv
`timescale 1ns/1ps
module psram_burst_tb;
  localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ads_n = 1'b1, adv_n = 1'b1, lbo_n = 1'b0, ce_n = 1'b1, cs0 = 1'b1, cs1_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, zz = 1'b0;
  logic [LN-1:0] bw_n = '1;
  logic [DW-1:0] dout;
  logic dout_drive;

  psram_burst #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ads_n(ads_n), .adv_n(adv_n),
    .lbo_n(lbo_n), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .dout(dout), .dout_drive(dout_drive)
  );

  typedef struct { int due; bit drv; logic [DW-1:0] d; string tag; } exp_t;
  exp_t sb[$];

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [64];
  logic [DW-1:0] pend = '0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit m_ilv = 1'b0, m_act = 1'b0;
  int seed = 1;

  function automatic logic [1:0] seq_low(logic [1:0] s, logic [1:0] i, bit il);
    if (il) return s ^ i;
    return 2'((int'(s) + int'(i)) % 4);
  endfunction

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a, int sd);
    logic [DW-1:0] r;
    for (int l = 0; l < LN; l++) r[l*LW +: LW] = LW'(int'(a) * 13 + l * 37 + sd * 5);
    return r;
  endfunction

  task automatic check(string tag, bit ok, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pre();
    @(negedge clk);
    ce_n = 1'b0; cs0 = 1'b1; cs1_n = 1'b0; zz = 1'b0; ads_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    din = pend; pend = '0;
  endtask

  task automatic push(bit ev, logic [DW-1:0] ed, string tag);
    exp_t e;
    e.due = edge_n + 2; e.drv = ev; e.d = ed; e.tag = tag;
    sb.push_back(e);
  endtask

  // wk: 0 read, 1 global write, 2 byte write with bwn
  task automatic beat(bit st, logic [AW-1:0] a, bit il, bit adv, int wk,
                      logic [LN-1:0] bwn, string tag);
    logic [AW-1:0] ea;
    logic [LN-1:0] m;
    logic [DW-1:0] w;
    pre();
    ads_n = !st; addr = a; lbo_n = il; adv_n = adv;
    if (wk == 1) gw_n = 1'b0;
    if (wk == 2) begin bwe_n = 1'b0; bw_n = bwn; end
    if (st) begin m_base = a; m_cnt = 2'd0; m_ilv = il; m_act = 1'b1; end
    else if (m_act && !adv) m_cnt = m_cnt + 2'd1;
    if (!st && !m_act) begin push(1'b0, '0, tag); return; end
    ea = {m_base[AW-1:2], seq_low(m_base[1:0], m_cnt, m_ilv)};
    m = (wk == 1) ? '1 : (wk == 2) ? ~bwn : '0;
    if (m != 0) begin
      w = pat(ea, seed); seed++;
      for (int l = 0; l < LN; l++) if (m[l]) ref_mem[ea][l*LW +: LW] = w[l*LW +: LW];
      pend = w;
      push(1'b0, '0, tag);
    end else begin
      push(1'b1, ref_mem[ea], tag);
    end
  endtask

  task automatic desel(int how, string tag);
    pre();
    if (how == 0) ce_n = 1'b1;
    else if (how == 1) cs0 = 1'b0;
    else cs1_n = 1'b1;
    m_act = 1'b0;
    push(1'b0, '0, tag);
  endtask

  task automatic sleep(string tag);
    pre();
    zz = 1'b1; ads_n = 1'b0; adv_n = 1'b0; gw_n = 1'b0; addr = 6'h3F;
    push(1'b0, '0, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0 && sb[0].due <= edge_n) begin
        e = sb.pop_front();
        if (e.drv) check(e.tag, dout_drive === 1'b1 && dout === e.d, dout, e.d);
        else check(e.tag, dout_drive === 1'b0 && dout === '0, {dout[DW-1:1], dout_drive}, '0);
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin : driver
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset drive", dout_drive === 1'b0 && dout === '0, dout, '0);
    rst_n = 1'b1;
    desel(0, "R1 after reset");
    // fill every word with global-write linear bursts
    for (int b = 0; b < 16; b++) begin
      beat(1, AW'(b * 4), 0, 0, 1, '1, "R7 fill");
      for (int k = 0; k < 3; k++) beat(0, '0, 0, 0, 1, '1, "R7 fill");
    end
    desel(0, "R9 idle");
    // linear vs interleaved order from an offset start
    beat(1, 6'h11, 0, 0, 0, '1, "R2 first beat");
    for (int k = 0; k < 3; k++) beat(0, '0, 0, 0, 0, '1, "R6 linear");
    beat(1, 6'h11, 1, 0, 0, '1, "R6 interleaved");
    for (int k = 0; k < 3; k++) beat(0, '0, 0, 0, 0, '1, "R6 interleaved");
    beat(1, 6'h2E, 1, 0, 0, '1, "R3 upper bits");
    for (int k = 0; k < 3; k++) beat(0, '0, 0, 0, 0, '1, "R3 upper bits");
    // wrap after four beats
    beat(1, 6'h07, 0, 0, 0, '1, "R4 wrap");
    for (int k = 0; k < 5; k++) beat(0, '0, 0, 0, 0, '1, "R4 wrap");
    // hold with advance high
    beat(1, 6'h09, 1, 0, 0, '1, "R5 hold");
    beat(0, '0, 0, 1, 0, '1, "R5 hold");
    beat(0, '0, 0, 0, 0, '1, "R5 step");
    beat(0, '0, 0, 1, 0, '1, "R5 hold");
    beat(0, '0, 0, 0, 0, '1, "R5 step");
    // byte write lanes 0 and 2, read straight after
    beat(1, 6'h21, 0, 0, 2, 4'b1010, "R7 byte write");
    beat(1, 6'h21, 0, 0, 0, '1, "R8 read after byte write");
    beat(1, 6'h30, 0, 0, 1, '1, "R7 global write");
    beat(1, 6'h30, 0, 0, 0, '1, "R8 read after write");
    beat(1, 6'h22, 0, 0, 2, 4'b1111, "R7 no lane selected is read");
    beat(1, 6'h22, 0, 0, 0, '1, "R7 untouched word");
    // deselect by each select input
    for (int h = 0; h < 3; h++) begin
      beat(1, 6'h13, 0, 0, 0, '1, "R9 before deselect");
      beat(0, '0, 0, 0, 0, '1, "R9 before deselect");
      desel(h, "R9 deselect");
      beat(0, '0, 0, 0, 0, '1, "R9 burst ended");
    end
    // sleep in the middle of a burst
    beat(1, 6'h19, 0, 0, 0, '1, "R11 before sleep");
    beat(0, '0, 0, 0, 0, '1, "R11 before sleep");
    sleep("R11 sleep");
    sleep("R11 sleep");
    beat(0, '0, 0, 0, 0, '1, "R11 resume");
    beat(0, '0, 0, 0, 0, '1, "R11 resume");
    beat(1, 6'h3F, 0, 0, 0, '1, "R11 memory held");
    // asynchronous output enable
    beat(1, 6'h05, 0, 0, 0, '1, "R10 read");
    beat(0, '0, 0, 0, 0, '1, "R10 read");
    @(posedge clk);
    #4 oe_n = 1'b1;
    #1 check("R10 oe high", dout_drive === 1'b0 && dout === '0, dout, '0);
    oe_n = 1'b0;
    #1 check("R10 oe low", dout_drive === 1'b1 && dout === ref_mem[6'h05], dout, ref_mem[6'h05]);
    for (int k = 0; k < 4; k++) desel(0, "R9 tail");
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule